// File: doc/BRIEF.md
# Absmax Activation Quantizer

This block turns a vector of signed fixed-point activations into signed 8-bit codes. The scale used for each vector is derived from that vector's largest magnitude. Elements arrive one per handshake on a valid/ready input stream and are held in an internal buffer. Once the last element is in, the block knows the vector's absolute maximum. A sequential divider then forms the reciprocal scale. The buffered elements are read back in their original order, multiplied by the scale, rounded and saturated, and sent out on a valid/ready output stream.

When the final element of a vector has been handed off, the block raises a one-cycle completion pulse. At the same time it publishes the scale it used, so that a downstream stage can undo the quantization later. The input is held off from the moment a vector is complete until its last code has left. The max search, the division and the output pass therefore run strictly one after another.

Scale format: the scale is an unsigned fixed-point number with `SCL_FRAC` fraction bits. With the default parameters it is 24 bits wide, with 16 fraction bits.

Top module: `aq_absmax_quant`

## Requirements
- R1: While reset is asserted and right after it, `in_ready` is 1, `out_valid` is 0, `done` is 0 and `scale_out` is 0. A reset in the middle of a vector abandons that vector.
- R2: The block takes exactly `VEC_LEN` input elements per vector. From the transfer of the last element until the last output transfer, `in_ready` is 0.
- R3: The scale is floor(2^(7+SCL_FRAC) / (M + EPS)). M is the largest magnitude in the vector, and the most negative input counts as magnitude 2^(IN_W-1). With the defaults this is floor(2^23/(M+1)).
- R4: Each output code is the input times the scale divided by 2^SCL_FRAC. It is rounded to the nearest integer, with ties going away from zero (for example, +0.5 becomes +1 and -1.5 becomes -2).
- R5: Codes saturate to the two's-complement range -128..+127. A rounded +128 becomes +127, while -128 stays -128.
- R6: The block emits `VEC_LEN` codes per vector, in arrival order. `out_last` is 1 exactly on the final code.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R8: `done` is 1 for exactly one cycle, the cycle after the final output transfer. `scale_out` takes the vector's scale in that same cycle and otherwise keeps its value.
- R9: An all-zero vector gives all-zero codes and a scale of 2^(7+SCL_FRAC), with no division fault.
- R10: An `in_valid` presented while `in_ready` is 0 is not taken. That element is accepted later, once `in_ready` returns, and the codes of the vector being emitted are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block can take an input element |
| in_data | input | IN_W | Signed fixed-point activation |
| out_valid | output | 1 | Output code present |
| out_ready | input | 1 | Downstream takes the code |
| out_data | output | OUT_W | Signed quantized code |
| out_last | output | 1 | Marks the final code of a vector |
| scale_out | output | OUT_W+SCL_FRAC | Scale of the last completed vector |
| done | output | 1 | One-cycle pulse after the final code transfer |

## Verification
The completion pulse for one vector and the acceptance of the first element of the next vector fall in the same cycle. This happens because the block returns to its input state exactly when `done` rises. The bench provokes this by holding `in_valid` high with the next vector's first element during the whole output pass. It then checks that `in_ready` stays low until the `done` cycle, and that `in_ready` and `done` are both high in that cycle. Finally it checks that the codes of both vectors match values computed from the rounding and saturation rules. Output stalls in the middle of a vector are also exercised, to check that the held code does not change while the input is pressing in.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_KICK = 2'd1,
    ST_DIV  = 2'd2,
    ST_EMIT = 2'd3
  } aq_state_e;
endpackage

// File: rtl/aq_vec_store.sv
module aq_vec_store #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (addr == AW'(i))) begin
        mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/aq_recip_div.sv
module aq_recip_div #(
  parameter int QW    = 24,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEN_W-1:0] divisor,
  output logic             fin,
  output logic [QW-1:0]    quot
);
  localparam int CW = $clog2(QW + 1);

  logic [QW-1:0]    num_q, num_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [DEN_W-1:0] div_q, div_n;
  logic [QW-1:0]    quot_q, quot_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             fin_q, fin_n;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W-1:0] rem_diff;
  logic             ge;

  always_comb begin
    rem_sh   = {rem_q, num_q[QW-1]};
    ge       = (rem_sh >= {1'b0, div_q});
    rem_diff = rem_sh[DEN_W-1:0] - div_q;
    num_n    = num_q;
    rem_n    = rem_q;
    div_n    = div_q;
    quot_n   = quot_q;
    cnt_n    = cnt_q;
    fin_n    = 1'b0;
    if (start) begin
      num_n  = QW'(1) << (QW - 1);
      rem_n  = '0;
      div_n  = divisor;
      quot_n = '0;
      cnt_n  = CW'(QW);
    end else if (cnt_q != '0) begin
      num_n  = num_q << 1;
      rem_n  = ge ? rem_diff : rem_sh[DEN_W-1:0];
      quot_n = {quot_q[QW-2:0], ge};
      cnt_n  = cnt_q - 1'b1;
      fin_n  = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      num_q  <= num_n;
      rem_q  <= rem_n;
      div_q  <= div_n;
      quot_q <= quot_n;
      cnt_q  <= cnt_n;
      fin_q  <= fin_n;
    end
  end

  assign fin  = fin_q;
  assign quot = quot_q;
endmodule

// File: rtl/aq_round_clamp.sv
module aq_round_clamp #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8,
  parameter int QW    = 24,
  parameter int SF    = 16
) (
  input  logic [IN_W-1:0]  din,
  input  logic [QW-1:0]    scale,
  output logic [OUT_W-1:0] dout
);
  localparam int MAG_W = IN_W + 1;
  localparam int PW    = MAG_W + QW;

  logic             neg;
  logic [MAG_W-1:0] ext, mag;
  logic [PW-1:0]    prod, rnd, shr, lim;
  logic [OUT_W-1:0] sat;

  always_comb begin
    neg  = din[IN_W-1];
    ext  = {din[IN_W-1], din};
    mag  = neg ? (~ext + 1'b1) : ext;
    prod = PW'(mag) * PW'(scale);
    rnd  = prod + (PW'(1) << (SF - 1));
    shr  = rnd >> SF;
    lim  = neg ? (PW'(1) << (OUT_W - 1)) : ((PW'(1) << (OUT_W - 1)) - 1'b1);
    sat  = (shr > lim) ? lim[OUT_W-1:0] : shr[OUT_W-1:0];
    dout = neg ? OUT_W'(~sat + 1'b1) : sat;
  end
endmodule

// File: rtl/aq_absmax_quant.sv
module aq_absmax_quant
  import aq_pkg::*;
#(
  parameter int VEC_LEN  = 8,
  parameter int IN_W     = 16,
  parameter int OUT_W    = 8,
  parameter int SCL_FRAC = 16,
  parameter int EPS      = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [IN_W-1:0]           in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OUT_W-1:0]          out_data,
  output logic                      out_last,
  output logic [OUT_W+SCL_FRAC-1:0] scale_out,
  output logic                      done
);
  localparam int IDX_W = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
  localparam int MAG_W = IN_W + 1;
  localparam int DEN_W = IN_W + 2;
  localparam int QW    = OUT_W + SCL_FRAC;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_LEN - 1);

  aq_state_e        st_q, st_n;
  logic [IDX_W-1:0] cnt_q, cnt_n;
  logic [MAG_W-1:0] max_q, max_n;
  logic [QW-1:0]    scale_q, scale_n;
  logic             done_q, done_n;

  logic             wr_en, kick, div_fin, idx_last;
  logic [MAG_W-1:0] in_ext, in_mag;
  logic [DEN_W-1:0] divisor;
  logic [QW-1:0]    quot;
  logic [IN_W-1:0]  rd_data;

  assign in_ext   = {in_data[IN_W-1], in_data};
  assign in_mag   = in_data[IN_W-1] ? (~in_ext + 1'b1) : in_ext;
  assign idx_last = (cnt_q == LAST_IDX);
  assign divisor  = DEN_W'(max_q) + DEN_W'(EPS);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    max_n     = max_q;
    scale_n   = scale_q;
    done_n    = 1'b0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    wr_en     = 1'b0;
    kick      = 1'b0;
    case (st_q)
      ST_LOAD: begin
        in_ready = 1'b1;
        if (in_valid) begin
          wr_en = 1'b1;
          if ((cnt_q == '0) || (in_mag > max_q)) begin
            max_n = in_mag;
          end
          if (idx_last) begin
            cnt_n = '0;
            st_n  = ST_KICK;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_KICK: begin
        kick = 1'b1;
        st_n = ST_DIV;
      end
      ST_DIV: begin
        if (div_fin) begin
          st_n = ST_EMIT;
        end
      end
      ST_EMIT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          if (idx_last) begin
            cnt_n   = '0;
            st_n    = ST_LOAD;
            done_n  = 1'b1;
            scale_n = quot;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: st_n = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LOAD;
      cnt_q   <= '0;
      max_q   <= '0;
      scale_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      max_q   <= max_n;
      scale_q <= scale_n;
      done_q  <= done_n;
    end
  end

  aq_vec_store #(.DEPTH(VEC_LEN), .W(IN_W), .AW(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (cnt_q),
    .wr_data (in_data),
    .rd_data (rd_data)
  );

  aq_recip_div #(.QW(QW), .DEN_W(DEN_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (kick),
    .divisor (divisor),
    .fin     (div_fin),
    .quot    (quot)
  );

  aq_round_clamp #(.IN_W(IN_W), .OUT_W(OUT_W), .QW(QW), .SF(SCL_FRAC)) u_rnd (
    .din   (rd_data),
    .scale (quot),
    .dout  (out_data)
  );

  assign out_last  = out_valid && idx_last;
  assign scale_out = scale_q;
  assign done      = done_q;
endmodule

// File: rtl/aq_absmax_quant_chk.sv
module aq_absmax_quant_chk #(
  parameter int OUT_W = 8,
  parameter int QW    = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last,
  input logic [QW-1:0]    scale_out,
  input logic             done
);
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last)); // R8
  AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(scale_out)); // R8
endmodule

bind aq_absmax_quant aq_absmax_quant_chk #(.OUT_W(OUT_W), .QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .scale_out (scale_out),
  .done      (done)
);

// File: tb/sim_aq_absmax_quant.sv
module sim_aq_absmax_quant;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 8;
  localparam int NV = 5;
  localparam int WD = 20000;

  // stimulus table; expected codes and scales are derived from R3..R5
  localparam logic signed [15:0] STIM [NV][VL] = '{
    '{16'sd100, -16'sd50, 16'sd256, -16'sd256, 16'sd3, 16'sd0, 16'sd128, -16'sd129},
    '{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0},
    '{-16'sd32768, 16'sd1000, -16'sd1, 16'sd5, 16'sd32767, -16'sd2, 16'sd0, 16'sd7},
    '{16'sd32767, -16'sd32767, 16'sd16384, -16'sd16384, 16'sd1, -16'sd1, 16'sd0, 16'sd8192},
    '{16'sd255, 16'sd1, -16'sd1, 16'sd3, -16'sd3, 16'sd0, -16'sd255, 16'sd2}
  };

  logic        clk, rst_n, in_valid, in_ready, out_valid, out_ready, out_last, done;
  logic [15:0] in_data;
  logic [7:0]  out_data;
  logic [23:0] scale_out;
  int n_chk, n_fail;

  aq_absmax_quant u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .scale_out(scale_out), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint exp_scale(int v);
    longint m = 0;
    for (int i = 0; i < VL; i++) begin
      longint a = STIM[v][i];
      if (a < 0) a = -a;
      if (a > m) m = a;
    end
    return (longint'(1) << 23) / (m + 1);
  endfunction

  function automatic longint exp_code(longint a, longint s);
    longint mag = (a < 0) ? -a : a;
    longint r = (mag * s + 32768) >>> 16;
    if (a < 0) return (r > 128) ? -128 : -r;
    return (r > 127) ? 127 : r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at a negedge
  task automatic send(int v, int first);
    for (int i = first; i < VL; i++) begin
      in_valid = 1'b1;
      in_data  = STIM[v][i];
      chk(in_ready == 1'b1, "R2 in_ready during load", in_ready, 1);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic recv(int v, bit pre);
    longint s = exp_scale(v);
    if (pre) begin
      in_valid = 1'b1;
      in_data  = STIM[v+1][0];
    end
    for (int k = 0; k < VL; k++) begin
      out_ready = 1'b1;
      while (!out_valid) begin
        chk(in_ready == 1'b0, "R2 in_ready while computing", in_ready, 0);
        @(negedge clk);
      end
      if (k == 2) begin
        logic [7:0] held = out_data;
        out_ready = 1'b0;
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          chk(out_valid && out_data == held, "R7 code held in stall", out_data, held);
          chk(in_ready == 1'b0, "R10 input refused during emit", in_ready, 0);
        end
        out_ready = 1'b1;
      end
      chk($signed(out_data) == exp_code(STIM[v][k], s), "R4 R5 R9 code value",
          $signed(out_data), exp_code(STIM[v][k], s));
      chk(out_last == (k == VL-1), "R6 last flag", out_last, (k == VL-1));
      chk(done == 1'b0, "R8 no early done", done, 0);
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk(done == 1'b1, "R8 done pulse", done, 1);
    chk(scale_out == s[23:0], "R3 scale value", scale_out, s);
    chk(in_ready == 1'b1, "R10 ready in done cycle", in_ready, 1);
    if (pre) begin
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0, "R8 done single cycle", done, 0);
      chk(scale_out == s[23:0], "R8 scale held", scale_out, s);
    end else begin
      in_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(scale_out == '0, "R1 reset scale", scale_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(0, 0);
    for (int v = 0; v < NV; v++) begin
      recv(v, v < NV-1);
      if (v < NV-1) send(v + 1, 1);
    end

    // reset in the middle of the output pass
    send(2, 0);
    while (!out_valid) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 mid-run reset valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 mid-run reset ready", in_ready, 1);
    chk(scale_out == '0, "R1 mid-run reset scale", scale_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(4, 0);
    recv(4, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule